// File: doc/BRIEF.md
# HDLC to AAL2 CPS-Packet Formatter

This block sits after an HDLC de-framer. It accepts one de-framed HDLC frame at a time as a byte stream marked with start and end flags. It turns that frame into a single AAL2 CPS-Packet on a byte-stream output with a valid/ready handshake. The frame carries three things the block strips off: a leading address of zero, one or two bytes, a control byte, and a two-byte frame check sequence at the end. The bytes in between form the body, which the block stores in an internal buffer while it counts them. The CPS-Packet header goes out before the payload, so the block only starts sending once the whole frame is in. The header it sends is three bytes: a channel identifier taken from configuration, the length indicator, the user-to-user field and a 5-bit header check.

A global mode input decides how the body is read. In wrap mode the whole body is the payload, and the user-to-user field comes from the top five bits of the control byte. In raw mode the first three body bytes are an existing CPS-Packet header. Of that header only the user-to-user field is kept. The channel identifier, length indicator and header check are all regenerated. A frame whose payload length falls outside 1 to 45 bytes is discarded and a sticky error output is raised.

Top module: `hdlc_cps_formatter`

## Requirements
- R1: The first `addr_len` bytes of a frame (0, 1 or 2, sampled with the start byte) are discarded. The byte after them is the control byte, and neither appears in the output.
- R2: The last two bytes of a frame are never sent. In wrap mode the payload is every byte between the control byte and those two bytes, in arrival order.
- R3: In wrap mode the user-to-user field equals bits 7:3 of the control byte. Bits 2:0 of the control byte have no effect.
- R4: Each packet starts with three header bytes. Byte 0 is `cid_cfg`. Byte 1 is {LI[5:0], UUI[4:3]}. Byte 2 is {UUI[2:0], HEC[4:0]}. LI is the payload byte count minus one.
- R5: The HEC is the remainder of the 19-bit value {CID, LI, UUI}, taken most significant bit first and multiplied by x^5, divided by x^5 + x^2 + 1. The initial value is zero.
- R6: With `raw_mode` = 1, the three body bytes after the control byte are an incoming header laid out as in R4. Its UUI is kept. Its CID, LI and HEC have no effect on the output. The payload is the bytes between that header and the last two bytes.
- R7: A frame whose payload would have fewer than 1 or more than 45 bytes produces no output and sets `err`. This includes a raw frame with fewer than 3 header bytes plus 1 payload byte. `err` stays set until reset, and the next valid frame is formatted normally.
- R8: `in_ready` is low from the cycle after an accepted frame's last byte until the final output byte has been loaded into the output register. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold.
- R9: Input bytes with `in_sop` low that arrive after a frame's end byte and before the next start byte are ignored.
- R10: `out_last` is high on the last payload byte of each packet and low on every other byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_mode | input | 1 | 1: body holds a complete CPS-Packet; 0: body is the payload |
| addr_len | input | 2 | Address bytes to strip (0..2; 3 acts as 2) |
| cid_cfg | input | 8 | Channel identifier placed in the header |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_ready | output | 1 | Block can take an input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Last byte of a CPS-Packet |
| out_ready | input | 1 | Downstream takes the output byte |
| err | output | 1 | Sticky length-error flag |

## Verification
The assertions assume `out_ready` is driven freely but that every packet leaving the block was built from a frame of legal length. The length indicator checked against the beat count is therefore always within range. They also assume `raw_mode`, `addr_len` and `cid_cfg` do not change between a frame's start byte and the end of its output. The bench holds these settings constant for each frame. It drives bytes only as the handshake allows, and it releases back-pressure on a fixed pseudo-random pattern, so every output stall is eventually resolved.

// File: rtl/hcf_pkg.sv
package hcf_pkg;
  localparam int HDR_B = 3;
  localparam int CRC_B = 2;
  localparam int LI_W  = 6;
  localparam int UUI_W = 5;
  localparam int HEC_W = 5;

  function automatic logic [HEC_W-1:0] hec5(input logic [18:0] m);
    logic [HEC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = 18; i >= 0; i--) begin
      fb = c[4] ^ m[i];
      c  = {c[3:0], 1'b0} ^ (fb ? 5'h05 : 5'h00);
    end
    return c;
  endfunction
endpackage

// File: rtl/hcf_buf.sv
module hcf_buf #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/hcf_rx.sv
module hcf_rx
  import hcf_pkg::*;
#(
  parameter int BUF_DEPTH = 64,
  parameter int MAX_PAY   = 45,
  localparam int AW       = $clog2(BUF_DEPTH),
  localparam int CW       = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [7:0]       in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic             raw_mode,
  input  logic [1:0]       addr_len,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [7:0]       wdata,
  output logic             go,
  output logic [LI_W-1:0]  len,
  output logic             off_raw,
  output logic [UUI_W-1:0] uui,
  output logic             err
);
  localparam logic [CW-1:0] FULL = CW'(BUF_DEPTH);
  localparam logic [CW-1:0] LO_N = CW'(CRC_B + 1);
  localparam logic [CW-1:0] LO_R = CW'(HDR_B + CRC_B + 1);
  localparam logic [CW-1:0] HI_N = CW'(CRC_B + MAX_PAY);
  localparam logic [CW-1:0] HI_R = CW'(HDR_B + CRC_B + MAX_PAY);
  localparam logic [CW-1:0] TRIM_N = CW'(CRC_B);
  localparam logic [CW-1:0] TRIM_R = CW'(HDR_B + CRC_B);

  logic [1:0]       pos_q, alen_q, cp, al, addr_eff, pos_nx;
  logic             raw_q, inpkt_q, rm, live, is_ctrl, is_body, fine;
  logic [CW-1:0]    wcnt_q, wc, wc_nx, plen_full;
  logic [UUI_W-1:0] ctrl_q;
  logic [1:0]       hb1_q;
  logic [2:0]       hb2_q;

  always_comb begin
    addr_eff  = (addr_len == 2'd3) ? 2'd2 : addr_len;
    cp        = in_sop ? 2'd0 : pos_q;
    al        = in_sop ? addr_eff : alen_q;
    rm        = in_sop ? raw_mode : raw_q;
    wc        = in_sop ? '0 : wcnt_q;
    live      = accept && (in_sop || inpkt_q);
    is_ctrl   = live && (cp == al);
    is_body   = live && (cp > al);
    we        = is_body && (wc < FULL);
    waddr     = wc[AW-1:0];
    wdata     = in_data;
    wc_nx     = we ? wc + CW'(1) : wc;
    pos_nx    = (cp == 2'd3) ? cp : cp + 2'd1;
    fine      = rm ? (wc_nx >= LO_R && wc_nx <= HI_R)
                   : (wc_nx >= LO_N && wc_nx <= HI_N);
    plen_full = wc_nx - (rm ? TRIM_R : TRIM_N);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0; alen_q <= '0; raw_q <= 1'b0; inpkt_q <= 1'b0;
      wcnt_q <= '0; ctrl_q <= '0; hb1_q <= '0; hb2_q <= '0;
      go <= 1'b0; len <= '0; off_raw <= 1'b0; uui <= '0; err <= 1'b0;
    end else begin
      go <= 1'b0;
      if (live) begin
        pos_q   <= pos_nx;
        wcnt_q  <= wc_nx;
        inpkt_q <= !in_eop;
        if (in_sop) begin
          alen_q <= addr_eff;
          raw_q  <= raw_mode;
        end
        if (is_ctrl) ctrl_q <= in_data[7:3];
        if (is_body && wc == CW'(1)) hb1_q <= in_data[1:0];
        if (is_body && wc == CW'(2)) hb2_q <= in_data[7:5];
        if (in_eop) begin
          if (fine) begin
            go      <= 1'b1;
            len     <= plen_full[LI_W-1:0];
            off_raw <= rm;
            uui     <= rm ? {hb1_q, hb2_q} : ctrl_q;
          end else begin
            err <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hcf_tx.sv
module hcf_tx
  import hcf_pkg::*;
#(
  parameter int BUF_DEPTH = 64,
  localparam int AW       = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [LI_W-1:0]  len,
  input  logic             off_raw,
  input  logic [UUI_W-1:0] uui,
  input  logic [7:0]       cid_cfg,
  input  logic [7:0]       rd_data,
  output logic [AW-1:0]    rd_addr,
  output logic             busy,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  input  logic             out_ready
);
  logic [7:0]       cid_q;
  logic [LI_W-1:0]  li_q, li_in;
  logic [UUI_W-1:0] uui_q;
  logic [HEC_W-1:0] hec_q;
  logic [AW-1:0]    rptr_q;
  logic [6:0]       si_q, last_q;
  logic             ld, adv, at_end;
  logic [7:0]       nxt;

  always_comb begin
    li_in   = len - LI_W'(1);
    ld      = busy && (!out_valid || out_ready);
    adv     = ld && (si_q >= 7'(HDR_B));
    rd_addr = adv ? rptr_q + AW'(1) : rptr_q;
    at_end  = (si_q == last_q);
    case (si_q)
      7'd0:    nxt = cid_q;
      7'd1:    nxt = {li_q, uui_q[4:3]};
      7'd2:    nxt = {uui_q[2:0], hec_q};
      default: nxt = rd_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; out_valid <= 1'b0; out_data <= '0; out_last <= 1'b0;
      cid_q <= '0; li_q <= '0; uui_q <= '0; hec_q <= '0;
      rptr_q <= '0; si_q <= '0; last_q <= '0;
    end else begin
      if (go) begin
        busy   <= 1'b1;
        si_q   <= '0;
        cid_q  <= cid_cfg;
        li_q   <= li_in;
        uui_q  <= uui;
        hec_q  <= hec5({cid_cfg, li_in, uui});
        rptr_q <= off_raw ? AW'(HDR_B) : '0;
        last_q <= {1'b0, len} + 7'(HDR_B - 1);
      end
      if (ld) begin
        out_valid <= 1'b1;
        out_data  <= nxt;
        out_last  <= at_end;
        si_q      <= si_q + 7'd1;
        if (adv) rptr_q <= rptr_q + AW'(1);
        if (at_end) busy <= 1'b0;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hdlc_cps_formatter.sv
module hdlc_cps_formatter
  import hcf_pkg::*;
#(
  parameter int BUF_DEPTH = 64,
  parameter int MAX_PAY   = 45,
  localparam int AW       = $clog2(BUF_DEPTH)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       raw_mode,
  input  logic [1:0] addr_len,
  input  logic [7:0] cid_cfg,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_eop,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  input  logic       out_ready,
  output logic       err
);
  logic             we, go, off_raw, busy;
  logic [AW-1:0]    waddr, rd_addr;
  logic [7:0]       wdata, rd_data;
  logic [LI_W-1:0]  len;
  logic [UUI_W-1:0] uui;

  assign in_ready = !(busy || go);

  hcf_rx #(.BUF_DEPTH(BUF_DEPTH), .MAX_PAY(MAX_PAY)) u_rx (
    .clk(clk), .rst(rst), .accept(in_valid && in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .raw_mode(raw_mode), .addr_len(addr_len),
    .we(we), .waddr(waddr), .wdata(wdata),
    .go(go), .len(len), .off_raw(off_raw), .uui(uui), .err(err)
  );

  hcf_buf #(.DEPTH(BUF_DEPTH), .DW(8)) u_buf (
    .clk(clk), .we(we), .wa(waddr), .wd(wdata), .ra(rd_addr), .rd(rd_data)
  );

  hcf_tx #(.BUF_DEPTH(BUF_DEPTH)) u_tx (
    .clk(clk), .rst(rst), .go(go), .len(len), .off_raw(off_raw), .uui(uui),
    .cid_cfg(cid_cfg), .rd_data(rd_data), .rd_addr(rd_addr), .busy(busy),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready)
  );
endmodule

// File: rtl/hcf_chk.sv
module hcf_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_eop,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       err
);
  logic [6:0] bcnt;
  logic [5:0] li_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt <= '0;
      li_cap <= '0;
    end else if (out_valid && out_ready) begin
      bcnt <= out_last ? 7'd0 : bcnt + 7'd1;
      if (bcnt == 7'd1) li_cap <= out_data[7:2];
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  assert_no_input_mid_packet_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_last |-> !in_ready);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(in_valid && in_ready && in_eop));

  assert_li_matches_length_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |-> bcnt == ({1'b0, li_cap} + 7'd3));
endmodule

bind hdlc_cps_formatter hcf_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_eop(in_eop), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .err(err)
);

// File: tb/sim_hdlc_cps_formatter.sv
module sim_hdlc_cps_formatter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       raw_mode = 1'b0;
  logic [1:0] addr_len = 2'd0;
  logic [7:0] cid_cfg = 8'd0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic       in_sop = 1'b0;
  logic       in_eop = 1'b0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_last;
  logic       out_ready = 1'b0;
  logic       err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  bit last_rdy;
  logic [7:0] pk [0:63];
  logic [7:0] pay [0:63];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  hdlc_cps_formatter u0 (
    .clk(clk), .rst(rst), .raw_mode(raw_mode), .addr_len(addr_len),
    .cid_cfg(cid_cfg), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready), .err(err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: run hung, got cycle %0d expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic [4:0] ref_hec(input [18:0] m);
    logic [23:0] v;
    v = {m, 5'b0};
    for (int i = 23; i >= 5; i--)
      if (v[i]) v = v ^ (24'h25 << (i - 5));
    return v[4:0];
  endfunction

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic push(input int n, input bit stray);
    for (int i = 0; i < n; i++) begin
      bit took = 0;
      while (!took) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = pk[i];
        in_sop   = !stray && (i == 0);
        in_eop   = !stray && (i == n - 1);
        took     = in_ready;
        @(posedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    last_rdy = in_ready;
  endtask

  task automatic pull(input int len, input logic [7:0] cid, input logic [4:0] uui,
                      input string tag);
    logic [5:0] li;
    logic [7:0] exp;
    int b, waitc;
    li = 6'(len - 1);
    b = 0; waitc = 0;
    while (b < len + 3 && waitc < 500) begin
      bit v, r, l;
      logic [7:0] d;
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[1];
      v = out_valid; r = out_ready; d = out_data; l = out_last;
      @(posedge clk);
      waitc++;
      if (v && r) begin
        if (b == 0) exp = cid;
        else if (b == 1) exp = {li, uui[4:3]};
        else if (b == 2) exp = {uui[2:0], ref_hec({cid, li, uui})};
        else exp = pay[b - 3];
        chk(d === exp && l === (b == len + 2),
            $sformatf("%s len %0d beat %0d: got %h last %b expected %h last %b",
                      tag, len, b, d, l, exp, (b == len + 2)));
        b++; waitc = 0;
      end
    end
    if (b < len + 3) chk(0, $sformatf("%s len %0d: got %0d beats expected %0d", tag, len, b, len + 3));
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      out_ready = 1'b1;
      if (out_valid) seen = 1;
    end
    out_ready = 1'b0;
    chk(!seen, $sformatf("%s: got out_valid %b expected 0", tag, seen));
  endtask

  // Wrap-mode frame: addr bytes, control, payload, two check bytes.
  task automatic build_wrap(input int al, input int len, input logic [7:0] ctrl, output int n);
    n = 0;
    for (int j = 0; j < al; j++) begin pk[n] = 8'(8'hA0 + j); n++; end
    pk[n] = ctrl; n++;
    for (int i = 0; i < len; i++) begin
      pay[i] = 8'(len * 5 + i * 11 + al);
      pk[n] = pay[i]; n++;
    end
    pk[n] = 8'hC3; n++;
    pk[n] = 8'h3C; n++;
  endtask

  initial begin
    int n;
    logic [7:0] ctrl, cid;
    logic [4:0] uin;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0 && err === 1'b0 && in_ready === 1'b1,
        $sformatf("R7 R8 reset: got valid %b err %b ready %b expected 0 0 1",
                  out_valid, err, in_ready));

    // Wrap mode, every address size and every legal length.
    for (int al = 0; al < 3; al++) begin
      for (int len = 1; len <= 45; len++) begin
        ctrl = {5'(len * 3 + al), 3'b101};
        cid  = 8'(len * 13 + al);
        raw_mode = 1'b0; addr_len = 2'(al); cid_cfg = cid;
        build_wrap(al, len, ctrl, n);
        push(n, 0);
        chk(last_rdy == 1'b0, $sformatf("R8 in_ready after frame: got %b expected 0", last_rdy));
        pull(len, cid, ctrl[7:3], "R1 R2 R3 R4 R5 R10");
      end
    end

    // Raw mode: incoming CID, LI, HEC are junk; only UUI must survive.
    for (int len = 1; len <= 45; len++) begin
      cid = 8'(len * 29 + 7);
      uin = 5'(len * 7);
      raw_mode = 1'b1; addr_len = 2'd1; cid_cfg = cid;
      n = 0;
      pk[n] = 8'h5A; n++;
      pk[n] = 8'hFF; n++;
      pk[n] = ~cid; n++;
      pk[n] = {6'(len + 17), uin[4:3]}; n++;
      pk[n] = {uin[2:0], 5'(5'h1F ^ 5'(len))}; n++;
      for (int i = 0; i < len; i++) begin
        pay[i] = 8'(len * 3 + i * 17);
        pk[n] = pay[i]; n++;
      end
      pk[n] = 8'h11; n++;
      pk[n] = 8'h22; n++;
      push(n, 0);
      pull(len, cid, uin, "R6 R4 R5 R10");
    end

    chk(err === 1'b0, $sformatf("R7 no error after legal frames: got %b expected 0", err));

    // Too long in wrap mode (46 bytes).
    raw_mode = 1'b0; addr_len = 2'd0; cid_cfg = 8'h42;
    build_wrap(0, 46, 8'h08, n);
    push(n, 0);
    chk(last_rdy == 1'b1, $sformatf("R7 ready after dropped frame: got %b expected 1", last_rdy));
    quiet(20, "R7 46-byte payload dropped");
    chk(err === 1'b1, $sformatf("R7 err after long frame: got %b expected 1", err));

    // Empty payload in wrap mode.
    build_wrap(2, 0, 8'h10, n);
    addr_len = 2'd2;
    push(n, 0);
    quiet(20, "R7 empty payload dropped");

    // Raw frame with header but no payload.
    raw_mode = 1'b1; addr_len = 2'd0;
    n = 0;
    for (int i = 0; i < 6; i++) begin pk[n] = 8'(i + 1); n++; end
    push(n, 0);
    quiet(20, "R7 raw without payload dropped");

    // Frame ending on the address byte.
    raw_mode = 1'b0; addr_len = 2'd1;
    pk[0] = 8'h77;
    push(1, 0);
    quiet(10, "R7 truncated frame dropped");
    chk(err === 1'b1, $sformatf("R7 err stays set: got %b expected 1", err));

    // Recovery: a legal frame after errors.
    raw_mode = 1'b0; addr_len = 2'd1; cid_cfg = 8'h9C;
    build_wrap(1, 10, 8'hF8, n);
    push(n, 0);
    pull(10, 8'h9C, 5'h1F, "R7 recovery");

    // Stray bytes with no start marker between frames.
    for (int i = 0; i < 5; i++) pk[i] = 8'(8'hE0 + i);
    push(5, 1);
    chk(last_rdy == 1'b1, $sformatf("R9 ready after stray bytes: got %b expected 1", last_rdy));
    quiet(10, "R9 stray bytes produce nothing");
    cid_cfg = 8'h3D;
    build_wrap(1, 4, 8'h50, n);
    push(n, 0);
    pull(4, 8'h3D, 5'h0A, "R9 frame after stray bytes");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule